// File: doc/BRIEF.md
# Segment Verification Gate Controller

This block stands between a functional circuit split into independent execution segments and a trusted proof checker. It keeps one "verified" flag and one "locked" flag per segment. The functional side raises an execute request for every segment it is about to enter. A requested segment that is already verified runs straight away. A requested segment that is neither verified nor locked holds the system in a stall while its index goes to the checker.

The checker interface is a single request/index output paired with a done/verdict input. Only one query is outstanding at a time. When several requested segments are unverified, they are queried in ascending index order. A satisfiable verdict marks the segment verified. An unsatisfiable verdict sets that segment's lock flag. The lock masks the segment's enable until reset, and because the segment can never become verified, the stall stays up for as long as it is requested.

Top module: `seg_gate_ctrl`

## Requirements
- R1: While rst_n is low, chk_req is 0. After reset every verified and locked flag is 0, so with exec_req all zero, seg_en and stall are 0.
- R2: For each segment i, seg_en[i] equals exec_req[i] AND verified[i] AND NOT locked[i]. It is combinational from exec_req.
- R3: stall is 1 exactly when some segment with exec_req set is not verified. A locked segment counts as not verified.
- R4: When chk_req is 0 and at least one requested segment is neither verified nor locked, chk_req is 1 after the next rising clock edge. chk_id then holds the lowest such index, as a binary number from 0 to NUM_SEG-1.
- R5: While chk_req is 1 and chk_done is 0, chk_req stays 1 and chk_id stays unchanged on the next cycle, even if exec_req changes.
- R6: A rising edge with chk_req=1, chk_done=1 and chk_sat=1 sets the verified flag of segment chk_id. A verified segment that is requested again produces no further chk_req.
- R7: A rising edge with chk_req=1, chk_done=1 and chk_sat=0 sets the locked flag of segment chk_id. A locked segment keeps seg_en at 0, is never queried again, and keeps stall at 1 while it is requested.
- R8: When several requested segments need a query, they are queried one at a time in ascending index order. stall falls only after every one of them has returned chk_sat=1.
- R9: chk_done while chk_req is 0 is ignored and changes no flag.
- R10: Verified and locked flags never clear except through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_req | input | NUM_SEG | One bit per segment about to execute |
| seg_en | output | NUM_SEG | Gated per-segment enable |
| stall | output | 1 | System hold while a requested segment is unverified |
| chk_req | output | 1 | Query outstanding to the proof checker |
| chk_id | output | ID_W | Index of the segment being queried |
| chk_done | input | 1 | Checker verdict valid |
| chk_sat | input | 1 | Verdict: 1 satisfiable, 0 unsatisfiable |

## Verification
The in-line assertions check on every cycle the behaviours that span a few cycles. These are: a held query stays stable until answered, an idle controller with pending work issues a query on the next edge, the flags are sticky, no segment is both verified and locked, and a query never targets a segment that is already resolved. Only the bench scenarios can show the ascending service order across a multi-segment request, that a locked segment is never queried again over a long window, that a stray verdict leaves the table untouched, and that reset wipes the verified flags. The bench reaches these cases with a reference model compared on every cycle plus directed checks.

// File: rtl/seg_gate_pkg.sv
package seg_gate_pkg;
  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_WAIT = 1'b1
  } gate_state_e;
endpackage

// File: rtl/seg_status_table.sv
module seg_status_table #(
  parameter int NUM_SEG = 8,
  parameter int ID_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_en,
  input  logic               upd_sat,
  input  logic [ID_W-1:0]    upd_id,
  output logic [NUM_SEG-1:0] ver_o,
  output logic [NUM_SEG-1:0] lock_o
);
  logic [NUM_SEG-1:0] ver_q, lock_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    logic hit, ver_d, lock_d, ver_ce, lock_ce;

    always_comb begin
      hit     = upd_en && (upd_id == ID_W'(g));
      ver_ce  = hit && upd_sat;
      lock_ce = hit && !upd_sat;
      ver_d   = 1'b1;
      lock_d  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ver_q[g]  <= 1'b0;
        lock_q[g] <= 1'b0;
      end else begin
        if (ver_ce)  ver_q[g]  <= ver_d;
        if (lock_ce) lock_q[g] <= lock_d;
      end
    end
  end

  assign ver_o  = ver_q;
  assign lock_o = lock_q;

  // R10: flags are sticky until reset
  assert_ver_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ver_q & $past(ver_q)) == $past(ver_q)));
  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
  // R7: a segment is never both verified and locked
  assert_ver_lock_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ver_q & lock_q) == '0);
endmodule

// File: rtl/seg_lowest_pick.sv
module seg_lowest_pick #(
  parameter int NUM_SEG = 8,
  parameter int ID_W    = 3
) (
  input  logic [NUM_SEG-1:0] vec_i,
  output logic               any_o,
  output logic [ID_W-1:0]    idx_o
);
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = NUM_SEG - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/seg_req_fsm.sv
module seg_req_fsm
  import seg_gate_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend_any,
  input  logic [ID_W-1:0] pend_idx,
  input  logic            chk_done,
  output logic            req_o,
  output logic [ID_W-1:0] id_o,
  output logic            upd_en_o
);
  gate_state_e st_q, st_d;
  logic [ID_W-1:0] id_q, id_d;
  logic id_ce;

  always_comb begin
    st_d     = st_q;
    id_d     = pend_idx;
    id_ce    = 1'b0;
    upd_en_o = 1'b0;
    case (st_q)
      GATE_IDLE: if (pend_any) begin
        st_d  = GATE_WAIT;
        id_ce = 1'b1;
      end
      GATE_WAIT: if (chk_done) begin
        st_d     = GATE_IDLE;
        upd_en_o = 1'b1;
      end
      default: st_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= GATE_IDLE;
      id_q <= '0;
    end else begin
      st_q <= st_d;
      if (id_ce) id_q <= id_d;
    end
  end

  assign req_o = (st_q == GATE_WAIT);
  assign id_o  = id_q;

  // R5: an unanswered query holds its index
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !chk_done) |=> (req_o && $stable(id_o)));
  // R4: idle with pending work issues a query on the next edge
  assert_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && pend_any) |=> req_o);
endmodule

// File: rtl/seg_gate_ctrl.sv
module seg_gate_ctrl #(
  parameter int NUM_SEG = 8,
  localparam int ID_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SEG-1:0] exec_req,
  output logic [NUM_SEG-1:0] seg_en,
  output logic               stall,
  output logic               chk_req,
  output logic [ID_W-1:0]    chk_id,
  input  logic               chk_done,
  input  logic               chk_sat
);
  logic [NUM_SEG-1:0] ver, lock, pend;
  logic               pend_any, upd_en;
  logic [ID_W-1:0]    pend_idx;

  assign pend   = exec_req & ~ver & ~lock;
  assign seg_en = exec_req & ver & ~lock;
  assign stall  = |(exec_req & ~ver);

  seg_status_table #(.NUM_SEG(NUM_SEG), .ID_W(ID_W)) u_table (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_sat(chk_sat),
    .upd_id(chk_id), .ver_o(ver), .lock_o(lock)
  );

  seg_lowest_pick #(.NUM_SEG(NUM_SEG), .ID_W(ID_W)) u_pick (
    .vec_i(pend), .any_o(pend_any), .idx_o(pend_idx)
  );

  seg_req_fsm #(.ID_W(ID_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .pend_idx(pend_idx),
    .chk_done(chk_done), .req_o(chk_req), .id_o(chk_id), .upd_en_o(upd_en)
  );

  // R7: a query never targets a resolved segment
  assert_query_unresolved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> (!ver[chk_id] && !lock[chk_id]));
  // R1: no query while in reset
  always_comb begin
    if (!rst_n) assert_no_req_in_reset_R1: assert (!chk_req);
  end
endmodule

// File: tb/sim_seg_gate_ctrl.sv
module sim_seg_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] exec_req;
  logic [N-1:0] seg_en;
  logic stall, chk_req, chk_done, chk_sat;
  logic [2:0] chk_id;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic resp_on = 1'b0, cmp_on = 1'b0;
  logic [N-1:0] verdict = '1;
  int lat = 0, wcnt = 0;
  int order[$];
  logic req_prev = 1'b0;

  // reference model state
  logic [N-1:0] m_ver, m_lock;
  bit m_wait;
  int m_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_gate_ctrl #(.NUM_SEG(N)) u0 (
    .clk(clk), .rst_n(rst_n), .exec_req(exec_req), .seg_en(seg_en),
    .stall(stall), .chk_req(chk_req), .chk_id(chk_id),
    .chk_done(chk_done), .chk_sat(chk_sat)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual %0d expected <100000", cyc);
      report();
    end
  end

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ver = '0; m_lock = '0; m_wait = 0; m_id = 0;
    end else begin
      automatic logic [N-1:0] p = exec_req & ~m_ver & ~m_lock;
      if (m_wait) begin
        if (chk_done) begin
          if (chk_sat) m_ver[m_id] = 1'b1; else m_lock[m_id] = 1'b1;
          m_wait = 0;
        end
      end else if (p != 0) begin
        for (int i = N - 1; i >= 0; i--) if (p[i]) m_id = i;
        m_wait = 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(seg_en == (exec_req & m_ver & ~m_lock), "R2", "seg_en vs model",
            seg_en, exec_req & m_ver & ~m_lock);
      check(stall == (|(exec_req & ~m_ver)), "R3", "stall vs model",
            stall, |(exec_req & ~m_ver));
      check(chk_req == m_wait, "R4", "chk_req vs model", chk_req, m_wait);
      if (m_wait) check(chk_id == m_id, "R4", "chk_id vs model", chk_id, m_id);
    end
    if (rst_n) begin
      if (chk_req && !req_prev) order.push_back(int'(chk_id));
      req_prev = chk_req;
    end
  end

  // checker responder
  always begin
    @(posedge clk); #1;
    if (resp_on) begin
      if (chk_done) chk_done = 1'b0;
      else if (chk_req) begin
        if (wcnt >= lat) begin
          chk_done = 1'b1; chk_sat = verdict[chk_id]; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wait_settle(input string req);
    int t = 0;
    @(negedge clk);
    while ((chk_req || (|(exec_req & ~m_ver & ~m_lock))) && t < 200) begin
      @(negedge clk); t++;
    end
    check(t < 200, req, "settle timeout", t, 0);
  endtask

  initial begin
    rst_n = 1'b0; exec_req = '0; chk_done = 1'b0; chk_sat = 1'b0;
    repeat (3) tick();
    check(chk_req == 1'b0, "R1", "chk_req in reset", chk_req, 0);
    check(seg_en == '0, "R1", "seg_en in reset", seg_en, 0);
    check(stall == 1'b0, "R1", "stall in reset", stall, 0);
    rst_n = 1'b1; cmp_on = 1'b1; resp_on = 1'b1;
    tick();

    // R6: single segment, satisfiable
    lat = 2; verdict = '1; exec_req = 8'h08;
    @(negedge clk);
    check(stall == 1'b1, "R3", "stall on unverified seg3", stall, 1);
    check(seg_en == 8'h00, "R2", "seg3 blocked before verdict", seg_en, 0);
    wait_settle("R6");
    check(seg_en == 8'h08, "R6", "seg3 enabled after sat", seg_en, 8'h08);
    check(stall == 1'b0, "R6", "stall released", stall, 0);
    tick(); exec_req = 8'h00; tick(); exec_req = 8'h08;
    order.delete();
    repeat (10) tick();
    check(order.size() == 0, "R6", "no re-query of verified seg3", order.size(), 0);

    // R8: ascending order over segments 2,5,7
    order.delete(); lat = 1; exec_req = 8'hA4;
    @(negedge clk);
    check(stall == 1'b1, "R8", "stall while queries run", stall, 1);
    wait_settle("R8");
    check(order.size() == 3, "R8", "query count", order.size(), 3);
    if (order.size() == 3) begin
      check(order[0] == 2, "R8", "first query", order[0], 2);
      check(order[1] == 5, "R8", "second query", order[1], 5);
      check(order[2] == 7, "R8", "third query", order[2], 7);
    end
    check(seg_en == 8'hA4, "R8", "all three enabled", seg_en, 8'hA4);
    check(stall == 1'b0, "R8", "stall falls after all sat", stall, 0);

    // R7: segment 1 unsatisfiable
    tick(); order.delete(); verdict = 8'hFD; lat = 0; exec_req = 8'h03;
    wait_settle("R7");
    check(order.size() == 2, "R7", "query count for segs 0,1", order.size(), 2);
    check(seg_en == 8'h01, "R7", "seg1 masked by lock", seg_en, 8'h01);
    check(stall == 1'b1, "R7", "stall held by locked seg1", stall, 1);
    order.delete();
    repeat (20) tick();
    check(order.size() == 0, "R7", "locked seg1 not re-queried", order.size(), 0);
    check(stall == 1'b1, "R7", "stall still held", stall, 1);
    exec_req = 8'h01;
    @(negedge clk);
    check(stall == 1'b0, "R7", "stall clear without seg1", stall, 0);

    // R9: stray verdict while idle
    tick(); resp_on = 1'b0; exec_req = 8'h00;
    tick(); chk_done = 1'b1; chk_sat = 1'b1;
    tick(); chk_done = 1'b0; exec_req = 8'h40;
    @(negedge clk);
    check(seg_en == 8'h00, "R9", "stray verdict did not verify seg6", seg_en, 0);
    check(stall == 1'b1, "R9", "seg6 still stalls", stall, 1);
    @(negedge clk);
    check(chk_req == 1'b1 && chk_id == 3'd6, "R9", "seg6 queried", {chk_req, chk_id}, 4'hE);
    tick(); chk_done = 1'b1; chk_sat = 1'b1;
    tick(); chk_done = 1'b0; resp_on = 1'b1;
    @(negedge clk);
    check(seg_en == 8'h40, "R9", "seg6 enabled after real verdict", seg_en, 8'h40);

    // R5: query held while exec_req changes
    tick(); lat = 6; verdict = '1; exec_req = 8'h10;
    @(negedge clk);
    tick(); exec_req = 8'h30;
    @(negedge clk);
    check(chk_req && chk_id == 3'd4, "R5", "seg4 query held", chk_id, 4);
    tick(); exec_req = 8'h20;
    @(negedge clk);
    check(chk_req && chk_id == 3'd4, "R5", "seg4 query still held", chk_id, 4);
    exec_req = 8'h30;
    wait_settle("R5");
    check(seg_en == 8'h30, "R5", "segs 4,5 enabled", seg_en, 8'h30);

    // R10: flags survive, reset wipes them
    tick(); exec_req = 8'h0A;
    @(negedge clk);
    check(seg_en == 8'h08, "R10", "seg3 kept, seg1 locked", seg_en, 8'h08);
    cmp_on = 1'b0; resp_on = 1'b0; rst_n = 1'b0; exec_req = 8'h08;
    tick(); rst_n = 1'b1;
    @(negedge clk);
    check(seg_en == 8'h00, "R10", "reset cleared seg3 verified flag", seg_en, 0);
    check(stall == 1'b1, "R10", "seg3 stalls after reset", stall, 1);

    report();
  end
endmodule